// File: doc/BRIEF.md
# Byte-Wide Three-Wire Serial Exchange Engine

This block holds one byte in a shift register that a host loads and reads through a simple register port. It exchanges that byte with a remote device over a synchronous three-wire link made of a serial data input, a serial data output and a shift clock. A transfer is a swap: while the held byte leaves on the output, most significant bit first, the incoming bits fill the register behind it. After eight bits the register holds the received byte.

The engine has two modes. In master mode it makes the shift clock itself from a programmable power-of-two division of the system clock, and any host write starts a transfer at once. In slave mode it follows a shift clock driven from outside, which it synchronises into the system clock domain. A completion flag is set when eight bits have moved and is cleared by any host write. While the flag is set, a slave ignores its shift clock, so a host can read a finished result without a stray edge corrupting it. The host also has an exchange operation that reads the old byte and writes a new one in the same cycle. The serial output can be released to high impedance so that several devices can share one data line.

Top module: `serial_xchg_engine`

## Requirements
- R1: After reset the completion flag `done` is 1, the register reads 0, `sclk_out` is 0 and `div_err` is 0.
- R2: A host write (`host_wr`) or exchange (`host_xchg`) loads `host_wdata` into the register at the clock edge and clears `done` from the next cycle. `host_rdata` always shows the register, so during an exchange cycle it shows the byte held before the load.
- R3: When `sdo_en` is 1, `sdo` equals bit 7 of the register, so the byte leaves most significant bit first and its first bit is valid as soon as it is loaded.
- R4: In master mode with a legal code (2 to 15), a write starts eight clock periods on `sclk_out`. The clock idles low, and each half period lasts 2^(code+1) system clocks, which is a divisor of 2^(code+2) (code 2 gives /16, code 15 gives /131072).
- R5: In master mode `sdi` is sampled when `sclk_out` rises and the register shifts left on each fall, with the sampled bit entering bit 0. On the eighth fall `done` becomes 1 and the register holds the received byte.
- R6: In slave mode the engine acts on each `sclk_in` edge at the third system clock edge after the change. A rising edge samples `sdi` and a falling edge shifts. The eighth fall sets `done` and leaves the received byte in the register.
- R7: A slave with `done` set ignores `sclk_in` entirely: the register and `sdo` stay unchanged.
- R8: In master mode a code of 0 or 1 is illegal. `div_err` reads 1 from the next cycle, a write loads the register and clears `done` but produces no clock, and an active transfer stops with `sclk_out` low.
- R9: When `sdo_en` is 0, `sdo` is high impedance.
- R10: A host write during a master transfer abandons it and restarts a full eight-bit transfer of the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = generate the shift clock, 0 = follow `sclk_in` |
| div_code | input | 4 | Master clock divider code |
| host_wr | input | 1 | Host write strobe |
| host_xchg | input | 1 | Host exchange strobe (read old, write new) |
| host_wdata | input | 8 | Byte to load |
| host_rdata | output | 8 | Current register contents |
| done | output | 1 | Transfer complete flag |
| div_err | output | 1 | Illegal divider code in master mode |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, tri-stated |
| sdo_en | input | 1 | Drive enable for `sdo` |

## Verification
The bench builds the engine with its default parameters, an 8-bit register and a base divisor exponent of 4, so codes 2, 3 and 4 give half periods of 8, 16 and 32 system clocks. Those three codes keep full master transfers short enough to repeat with different data, including a restart in the middle of a transfer. Codes 0 and 1 cover the illegal-code path. The larger codes follow the same shifted-limit arithmetic but would need up to a million cycles per byte, so the bench does not run them.

// File: rtl/sx_pkg.sv
package sx_pkg;
    // Smallest divider code that produces a clock
    localparam int unsigned SX_MIN_CODE = 2;
    // Codes are mapped so that SX_MIN_CODE gives 2^BASE_LOG2; half period exponent offset
    localparam int unsigned SX_HALF_OFS = 3;
    // Synchroniser depth for the external shift clock (third stage is the edge reference)
    localparam int unsigned SX_SYNC_DEPTH = 3;
endpackage

// File: rtl/sx_edge_sync.sv
module sx_edge_sync
    import sx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [SX_SYNC_DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[SX_SYNC_DEPTH-2:0], async_in};
        rise   = pipe_q[SX_SYNC_DEPTH-2] & ~pipe_q[SX_SYNC_DEPTH-1];
        fall   = ~pipe_q[SX_SYNC_DEPTH-2] & pipe_q[SX_SYNC_DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // R6: one synchronised edge cannot be reported twice in a row
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall);
endmodule

// File: rtl/sx_rate_gen.sv
module sx_rate_gen
    import sx_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 4,
    parameter int unsigned CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic              tick
);
    localparam int unsigned CNT_W = BASE_LOG2 + (1 << CODE_W) - SX_HALF_OFS;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        legal = (code >= CODE_W'(SX_MIN_CODE));
        limit = '0;
        if (legal)
            limit = (CNT_W'(1) << (BASE_LOG2 + 32'(code) - SX_HALF_OFS)) - CNT_W'(1);
        tick  = run && legal && (cnt_q == limit);
        if (restart || !run || !legal) cnt_d = '0;
        else if (tick)                 cnt_d = '0;
        else                           cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a restart always begins a fresh half period
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R8: nothing counts under an illegal code
    a_r8_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (cnt_q == '0));
endmodule

// File: rtl/serial_xchg_engine.sv
module serial_xchg_engine
    import sx_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BASE_LOG2 = 4,
    parameter int unsigned CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [CODE_W-1:0] div_code,
    input  logic              host_wr,
    input  logic              host_xchg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              done,
    output logic              div_err,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdi,
    output logic              sdo,
    input  logic              sdo_en
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [BIT_W-1:0]  bitcnt;
        logic              busy;
        logic              done;
        logic              sclk;
        logic              samp;
        logic              err;
    } xe_state_t;

    xe_state_t st_d, st_q;

    logic wr_any;
    logic legal, tick;
    logic ext_rise, ext_fall;

    assign wr_any = host_wr | host_xchg;

    sx_rate_gen #(
        .BASE_LOG2 (BASE_LOG2),
        .CODE_W    (CODE_W)
    ) i_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_any),
        .run     (st_q.busy & master_mode),
        .code    (div_code),
        .legal   (legal),
        .tick    (tick)
    );

    sx_edge_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = master_mode & ~legal;
        if (wr_any) begin
            st_d.shreg  = host_wdata;
            st_d.done   = 1'b0;
            st_d.bitcnt = '0;
            st_d.sclk   = 1'b0;
            st_d.busy   = master_mode & legal;
        end else if (master_mode) begin
            if (st_q.busy && !legal) begin
                st_d.busy = 1'b0;
                st_d.sclk = 1'b0;
            end else if (tick) begin
                if (!st_q.sclk) begin
                    st_d.sclk = 1'b1;
                    st_d.samp = sdi;
                end else begin
                    st_d.sclk  = 1'b0;
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], st_q.samp};
                    if (st_q.bitcnt == LAST_BIT) begin
                        st_d.bitcnt = '0;
                        st_d.done   = 1'b1;
                        st_d.busy   = 1'b0;
                    end else begin
                        st_d.bitcnt = st_q.bitcnt + BIT_W'(1);
                    end
                end
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.sclk = 1'b0;
            if (!st_q.done) begin
                if (ext_rise) st_d.samp = sdi;
                if (ext_fall) begin
                    st_d.shreg = {st_q.shreg[DATA_W-2:0], st_q.samp};
                    if (st_q.bitcnt == LAST_BIT) begin
                        st_d.bitcnt = '0;
                        st_d.done   = 1'b1;
                    end else begin
                        st_d.bitcnt = st_q.bitcnt + BIT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.shreg;
    assign done       = st_q.done;
    assign div_err    = st_q.err;
    assign sclk_out   = st_q.sclk;
    assign sdo        = sdo_en ? st_q.shreg[DATA_W-1] : 1'bz;

    // R2: any host write clears the flag and lands the data
    a_r2_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !done);
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> (host_rdata == $past(host_wdata)));
    // R3: the driven output follows the top bit of the register
    a_r3_msb_out: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> (sdo == host_rdata[DATA_W-1]));
    // R4: a finished or idle engine holds the shift clock low
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk_out);
    // R7: a completed slave keeps its byte
    a_r7_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && done && !wr_any) |=> $stable(host_rdata));
    // R8: an illegal code never lets the clock rise
    a_r8_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && div_code < CODE_W'(SX_MIN_CODE)) |=> !sclk_out);
endmodule

// File: tb/test_serial_xchg_engine.sv
`timescale 1ns/1ps
module test_serial_xchg_engine;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       master_mode;
    logic [3:0] div_code;
    logic       host_wr, host_xchg;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       done, div_err;
    logic       sclk_in, sclk_out, sdi, sdo, sdo_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    serial_xchg_engine i_serial_xchg_engine (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .div_code(div_code),
        .host_wr(host_wr), .host_xchg(host_xchg), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .done(done), .div_err(div_err),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_reg, m_done, m_busy, m_div, m_sclk, m_bits, m_samp, m_err;
    int y0, y1, y2, half;
    bit m_legal, m_wr, m_rise, m_fall;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_reg = 0; m_done = 1; m_busy = 0; m_div = 0; m_sclk = 0;
            m_bits = 0; m_samp = 0; m_err = 0; y0 = 0; y1 = 0; y2 = 0;
        end else begin
            m_legal = (div_code >= 2);
            half    = 1 << (div_code + 1);
            m_wr    = host_wr || host_xchg;
            m_rise  = (y1 == 1) && (y2 == 0);
            m_fall  = (y1 == 0) && (y2 == 1);
            m_err   = (master_mode && !m_legal) ? 1 : 0;
            if (m_wr) begin
                m_reg = host_wdata; m_done = 0; m_bits = 0; m_div = 0; m_sclk = 0;
                m_busy = (master_mode && m_legal) ? 1 : 0;
            end else if (master_mode) begin
                if (m_busy == 1 && m_legal) begin
                    if (m_div == half - 1) begin
                        m_div = 0;
                        if (m_sclk == 0) begin
                            m_sclk = 1; m_samp = sdi;
                        end else begin
                            m_sclk = 0;
                            m_reg  = ((m_reg << 1) | m_samp) & 8'hFF;
                            m_bits++;
                            if (m_bits == 8) begin m_bits = 0; m_done = 1; m_busy = 0; end
                        end
                    end else begin
                        m_div++;
                    end
                end else begin
                    m_busy = 0; m_div = 0; m_sclk = 0;
                end
            end else begin
                m_busy = 0; m_div = 0; m_sclk = 0;
                if (m_done == 0) begin
                    if (m_rise) m_samp = sdi;
                    if (m_fall) begin
                        m_reg = ((m_reg << 1) | m_samp) & 8'hFF;
                        m_bits++;
                        if (m_bits == 8) begin m_bits = 0; m_done = 1; end
                    end
                end
            end
            y2 = y1; y1 = y0; y0 = sclk_in;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 register contents", host_rdata, m_reg);
            chk("R5 done flag", done, m_done);
            chk("R4 shift clock", sclk_out, m_sclk);
            chk("R8 error flag", div_err, m_err);
            if (sdo_en) begin
                chk("R3 serial out", sdo, (m_reg >> 7) & 1);
            end else begin
                n_tests++;
                if (sdo !== 1'bz) begin
                    n_fail++;
                    $display("FAIL R9 release: actual %b expected z", sdo);
                end
            end
        end
    end

    // ---------------- remote peer for master transfers ----------------
    bit       peer_on;
    logic [7:0] peer_byte, cap;
    int       peer_falls, rise_at, fall_at;
    logic     prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (peer_on) begin
            if (prev_sclk && !sclk_out) begin
                peer_falls++;
                if (fall_at < 0) fall_at = cyc;
                if (peer_falls < 8) sdi = peer_byte[7 - peer_falls];
            end
            if (!prev_sclk && sclk_out) begin
                cap = {cap[6:0], sdo};
                if (rise_at < 0) rise_at = cyc;
            end
        end
        prev_sclk = sclk_out;
    end

    task automatic host_op(input bit xchg, input logic [7:0] d, input logic [7:0] pd,
                           input int prev);
        @(posedge clk); #2;
        if (peer_on) begin
            peer_byte = pd; peer_falls = 0; sdi = pd[7];
            cap = 8'h00; rise_at = -1; fall_at = -1;
        end
        host_wr = !xchg; host_xchg = xchg; host_wdata = d;
        @(negedge clk);
        if (xchg) chk("R2 exchange returns previous byte", host_rdata, prev);
        @(posedge clk); #2;
        host_wr = 1'b0; host_xchg = 1'b0;
    endtask

    task automatic wait_done(input int limit, input string req);
        int n = 0;
        @(negedge clk);
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(req, done, 1);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic slave_byte(input logic [7:0] d, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sdi = d[7 - i];
            cycles(2);
            got = {got[6:0], sdo};
            sclk_in = 1'b1;
            cycles(5);
            sclk_in = 1'b0;
            cycles(5);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] got;
        int highs;
        rst_n = 1'b0; master_mode = 1'b1; div_code = 4'd2;
        host_wr = 1'b0; host_xchg = 1'b0; host_wdata = 8'h00;
        sclk_in = 1'b0; sdi = 1'b0; sdo_en = 1'b1; peer_on = 1'b1;
        peer_byte = 8'h00; cap = 8'h00; peer_falls = 0; rise_at = -1; fall_at = -1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done, 1);
        chk("R1 register after reset", host_rdata, 0);
        chk("R1 clock after reset", sclk_out, 0);
        chk("R1 error after reset", div_err, 0);

        // Master, code 2: half period 8
        host_op(1'b0, 8'hA5, 8'h3C, 0);
        wait_done(400, "R5 master completes at code 2");
        chk("R5 received byte code 2", host_rdata, 8'h3C);
        chk("R3 transmitted byte MSB first", cap, 8'hA5);
        chk("R4 half period code 2", fall_at - rise_at, 8);

        // Master exchange, code 3: half period 16
        div_code = 4'd3;
        host_op(1'b1, 8'h5A, 8'hC3, 8'h3C);
        wait_done(800, "R5 master completes at code 3");
        chk("R5 received byte code 3", host_rdata, 8'hC3);
        chk("R3 transmitted byte code 3", cap, 8'h5A);
        chk("R4 half period code 3", fall_at - rise_at, 16);

        // R10: restart in the middle of a code 4 transfer
        div_code = 4'd4;
        host_op(1'b0, 8'h11, 8'h00, 0);
        cycles(100);
        while (!sclk_out) @(negedge clk);
        while (sclk_out) @(negedge clk);
        host_op(1'b0, 8'h81, 8'h7E, 0);
        wait_done(1200, "R10 restarted transfer completes");
        chk("R10 received byte after restart", host_rdata, 8'h7E);
        chk("R10 full new byte sent", cap, 8'h81);
        chk("R4 half period code 4", fall_at - rise_at, 32);

        // R8: illegal codes
        cycles(1);
        div_code = 4'd1;
        cycles(2);
        chk("R8 error for code 1", div_err, 1);
        host_op(1'b0, 8'h42, 8'h00, 0);
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sclk_out) highs++;
        end
        chk("R8 no clock under illegal code", highs, 0);
        chk("R8 done stays clear", done, 0);
        chk("R8 register loaded", host_rdata, 8'h42);
        div_code = 4'd0;
        cycles(2);
        chk("R8 error for code 0", div_err, 1);
        div_code = 4'd2;
        cycles(2);
        chk("R8 error clears for legal code", div_err, 0);

        // R9: release of the serial output
        sdo_en = 1'b0;
        @(negedge clk);
        n_tests++;
        if (sdo !== 1'bz) begin
            n_fail++;
            $display("FAIL R9 released output: actual %b expected z", sdo);
        end
        cycles(1);
        sdo_en = 1'b1;
        @(negedge clk);
        chk("R3 driven output shows MSB", sdo, 0);

        // Slave transfer
        peer_on = 1'b0;
        cycles(1);
        master_mode = 1'b0;
        host_op(1'b0, 8'h96, 8'h00, 0);
        slave_byte(8'h4B, got);
        @(negedge clk);
        chk("R6 slave done", done, 1);
        chk("R6 slave received byte", host_rdata, 8'h4B);
        chk("R6 slave transmitted byte", got, 8'h96);
        chk("R4 slave mode keeps clock low", sclk_out, 0);

        // R7: clocks while done is set are ignored
        slave_byte(8'hFF, got);
        @(negedge clk);
        chk("R7 register untouched", host_rdata, 8'h4B);
        chk("R7 done still set", done, 1);
        chk("R7 output held", got, 8'h00);

        // Slave exchange and second byte
        host_op(1'b1, 8'h0F, 8'h00, 8'h4B);
        slave_byte(8'hE1, got);
        @(negedge clk);
        chk("R6 second slave byte", host_rdata, 8'hE1);
        chk("R6 second transmitted byte", got, 8'h0F);

        cycles(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule